// File: doc/BRIEF.md
# Weighted Round Robin Urgency Scheduler

This block chooses which of N queues is served next. Each queue has a programmable weight and a signed urgency counter. When a decision is requested, every queue that is marked active has its weight added to its counter. The block then searches for the active queue with the largest counter and grants that queue. The granted queue's counter is then reduced by the total weight of all queues that were active. Over many decisions, each active queue receives grants in proportion to its weight.

The maximum search is bit-serial across all queues at once. It works one bit slice per cycle, starting at the sign bit and ending at bit zero. In each slice, if any queue that is still a candidate has a 1, every candidate with a 0 drops out for the rest of the search. Because the counters are two's-complement, the sign slice is compared inverted. A decision therefore takes a fixed number of cycles, and the grant appears as a one-cycle pulse together with the queue number.

The controller has three states:

- `ST_IDLE` waits for a request. Transition *accept* goes to `ST_SEARCH` when a request arrives with a non-empty active mask. Otherwise it stays in `ST_IDLE`.
- `ST_SEARCH` handles one slice per cycle. Transition *last slice* goes to `ST_FINISH` after bit zero.
- `ST_FINISH` resolves ties, issues the grant, updates the winner's counter, and takes transition *done* back to `ST_IDLE`.

Top module: `wrr_urgency_sched`

## Requirements
- R1: After reset, every counter and every weight is zero and `grant_valid` is low.
- R2: A write with `wt_we` high stores `wt_data` as the weight of queue `wt_addr`. A decision accepted on that same edge still uses the old weight. Later decisions use the new one.
- R3: On the accept edge (`req` high in `ST_IDLE` with a non-zero `act_mask`), each queue whose mask bit is 1 has its weight added to its counter. All other counters keep their value.
- R4: The grant goes to the active queue with the largest counter. Counters are compared as two's-complement values of width weight bits + log2(N) + 1, which is 13 bits with the defaults.
- R5: When several active queues share the largest value, the lowest-numbered one is granted.
- R6: With the grant, the winner's counter is reduced by the sum of the weights of all queues that were active at the accept edge.
- R7: `grant_valid` is high for exactly one cycle, counter width + 2 clock edges after the accept edge (the accept edge counts as edge 1). `grant_id` carries the queue number while `grant_valid` is high.
- R8: A request whose `act_mask` is all zero produces no grant and changes no counter.
- R9: While a decision is in progress, `req` and `act_mask` are ignored.
- R10: A weight write made while a decision is in progress does not change that decision or its counter update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_mask | input | NQ | One bit per queue; 1 marks the queue as active |
| req | input | 1 | Request for a scheduling decision |
| wt_we | input | 1 | Weight write strobe |
| wt_addr | input | log2(NQ) | Queue whose weight is written |
| wt_data | input | WW | New weight value |
| grant_valid | output | 1 | One-cycle pulse marking a grant |
| grant_id | output | log2(NQ) | Number of the granted queue |

## Verification
A weight write and the acceptance of a decision can happen on the same clock edge. The bench provokes this by raising `wt_we` and `req` together for one cycle. A reference model in the bench applies the write only after it has accumulated the counters, and the following grants are compared against that model. The other case where two functions overlap is a new request or mask change, or a weight write, while a search is under way. The bench expects the decision already in progress to finish unchanged and the extra request to produce no second grant.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_FINISH = 2'd2
    } wrr_state_e;
endpackage

// File: rtl/wrr_active_sum.sv
module wrr_active_sum #(
    parameter int NQ = 8,
    parameter int WW = 9,
    parameter int SW = 13
) (
    input  logic [NQ-1:0]         mask,
    input  logic [NQ-1:0][WW-1:0] wts,
    output logic [SW-1:0]         total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < NQ; i++) begin
            if (mask[i]) total = total + {{(SW-WW){1'b0}}, wts[i]};
        end
    end
endmodule

// File: rtl/wrr_slice_step.sv
module wrr_slice_step #(
    parameter int NQ = 8
) (
    input  logic [NQ-1:0] en_in,
    input  logic [NQ-1:0] bits,
    output logic [NQ-1:0] en_out
);
    logic [NQ-1:0] hits;
    assign hits   = en_in & bits;
    // a candidate with a 0 drops out only if some candidate holds a 1
    assign en_out = (|hits) ? hits : en_in;
endmodule

// File: rtl/wrr_lowest_pick.sv
module wrr_lowest_pick #(
    parameter int NQ = 8,
    parameter int QW = 3
) (
    input  logic [NQ-1:0] cand,
    output logic [QW-1:0] id
);
    always_comb begin
        id = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (cand[i]) id = QW'(i);
        end
    end
endmodule

// File: rtl/wrr_urgency_sched.sv
module wrr_urgency_sched
    import wrr_pkg::*;
#(
    parameter int NQ = 8,
    parameter int WW = 9,
    localparam int QW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] act_mask,
    input  logic          req,
    input  logic          wt_we,
    input  logic [QW-1:0] wt_addr,
    input  logic [WW-1:0] wt_data,
    output logic          grant_valid,
    output logic [QW-1:0] grant_id
);
    localparam int CW = WW + QW + 1;
    localparam int SB = $clog2(CW);
    localparam logic [SB-1:0] TOP_SLICE = SB'(CW - 1);

    wrr_state_e state_q, state_d;

    logic [NQ-1:0][CW-1:0] cnt_q;
    logic [NQ-1:0][WW-1:0] wt_q;
    logic [NQ-1:0]         mask_q;
    logic [NQ-1:0]         en_q;
    logic [NQ-1:0]         en_nxt;
    logic [NQ-1:0]         slice_bits;
    logic [SB-1:0]         slice_q;
    logic [CW-1:0]         sum_live;
    logic [CW-1:0]         sum_q;
    logic [QW-1:0]         pick_id;
    logic                  accept;

    assign accept = (state_q == ST_IDLE) && req && (|act_mask);

    // per-queue slice bit; sign slice inverted so non-negative wins
    for (genvar g = 0; g < NQ; g++) begin : g_slice
        assign slice_bits[g] = cnt_q[g][slice_q] ^ (slice_q == TOP_SLICE);
    end

    wrr_active_sum #(.NQ(NQ), .WW(WW), .SW(CW)) u_sum (
        .mask  (act_mask),
        .wts   (wt_q),
        .total (sum_live)
    );

    wrr_slice_step #(.NQ(NQ)) u_step (
        .en_in  (en_q),
        .bits   (slice_bits),
        .en_out (en_nxt)
    );

    wrr_lowest_pick #(.NQ(NQ), .QW(QW)) u_pick (
        .cand (en_q),
        .id   (pick_id)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SEARCH;
            ST_SEARCH: if (slice_q == '0) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // weight storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wt_q <= '0;
        end else if (wt_we) begin
            wt_q[wt_addr] <= wt_data;
        end
    end

    // urgency counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            for (int i = 0; i < NQ; i++) begin
                if (accept && act_mask[i]) begin
                    cnt_q[i] <= cnt_q[i] + {{(CW-WW){1'b0}}, wt_q[i]};
                end else if ((state_q == ST_FINISH) && (pick_id == QW'(i))) begin
                    cnt_q[i] <= cnt_q[i] - sum_q;
                end
            end
        end
    end

    // search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            en_q    <= '0;
            slice_q <= '0;
            sum_q   <= '0;
        end else if (accept) begin
            mask_q  <= act_mask;
            en_q    <= act_mask;
            slice_q <= TOP_SLICE;
            sum_q   <= sum_live;
        end else if (state_q == ST_SEARCH) begin
            en_q <= en_nxt;
            if (slice_q != '0) slice_q <= slice_q - 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_id    <= '0;
        end else begin
            grant_valid <= (state_q == ST_FINISH);
            if (state_q == ST_FINISH) grant_id <= pick_id;
        end
    end
endmodule

// File: rtl/wrr_urgency_sched_chk.sv
module wrr_urgency_sched_chk
    import wrr_pkg::*;
#(
    parameter int NQ = 8,
    parameter int WW = 9,
    localparam int QW = $clog2(NQ)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic [NQ-1:0] act_mask,
    input logic          grant_valid,
    input logic [QW-1:0] grant_id,
    input wrr_state_e    state_q,
    input logic [NQ-1:0] mask_q,
    input logic [NQ-1:0] en_q
);
    localparam int CW = WW + QW + 1;
    logic [7:0] lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat <= '0;
        else if (state_q == ST_IDLE && req && (|act_mask)) lat <= 8'd1;
        else if (lat != '0 && lat != 8'hFF) lat <= lat + 8'd1;
    end

    assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid);

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (lat == 8'(CW + 2)));

    assert_active_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> mask_q[grant_id]);

    assert_survivor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH) |-> (en_q != '0));

    assert_empty_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && act_mask == '0) |=> (state_q == ST_IDLE));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(mask_q));
endmodule

bind wrr_urgency_sched wrr_urgency_sched_chk #(.NQ(NQ), .WW(WW)) u_chk (.*);

// File: tb/wrr_urgency_sched_test.sv
`timescale 1ns/1ps
module wrr_urgency_sched_test;
    localparam int NQ = 8;
    localparam int WW = 9;
    localparam int QW = $clog2(NQ);
    localparam int CW = WW + QW + 1;

    typedef struct { int id; int cyc; } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NQ-1:0] act_mask = '0;
    logic          req = 1'b0;
    logic          wt_we = 1'b0;
    logic [QW-1:0] wt_addr = '0;
    logic [WW-1:0] wt_data = '0;
    logic          grant_valid;
    logic [QW-1:0] grant_id;

    int   total = 0, bad = 0, cyc = 0, gcount = 0;
    int   mw [NQ];
    int   mc [NQ];
    exp_t sbq [$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wrr_urgency_sched #(.NQ(NQ), .WW(WW)) uut (
        .clk(clk), .rst_n(rst_n), .act_mask(act_mask), .req(req),
        .wt_we(wt_we), .wt_addr(wt_addr), .wt_data(wt_data),
        .grant_valid(grant_valid), .grant_id(grant_id)
    );

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    function automatic int wrapc(input int v);
        int m = 1 << CW;
        int h = 1 << (CW - 1);
        int x = (v + h) % m;
        if (x < 0) x += m;
        return x - h;
    endfunction

    // reference model: returns winner or -1
    function automatic int model(input logic [NQ-1:0] m);
        int sum = 0, best = -1;
        if (m == '0) return -1;
        for (int i = 0; i < NQ; i++) if (m[i]) begin
            mc[i] = wrapc(mc[i] + mw[i]);
            sum += mw[i];
        end
        for (int i = 0; i < NQ; i++)
            if (m[i] && (best < 0 || mc[i] > mc[best])) best = i;
        mc[best] = wrapc(mc[best] - sum);
        return best;
    endfunction

    task automatic start(input logic [NQ-1:0] m);
        int w;
        exp_t e;
        @(negedge clk);
        act_mask = m;
        req = 1'b1;
        w = model(m);
        if (w >= 0) begin
            e.id = w; e.cyc = cyc + CW + 2;
            sbq.push_back(e);
        end
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wt_we = 1'b1; wt_addr = QW'(a); wt_data = WW'(d);
        @(negedge clk);
        wt_we = 1'b0;
        mw[a] = d;
    endtask

    task automatic decide(input logic [NQ-1:0] m);
        start(m);
        idle(CW + 3);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && grant_valid) begin
            exp_t e;
            gcount++;
            if (sbq.size() == 0) begin
                chk(1'b0, "R9 unexpected grant", int'(grant_id), -1);
            end else begin
                e = sbq.pop_front();
                chk(int'(grant_id) == e.id, "R4/R5/R6 grant id", int'(grant_id), e.id);
                chk(cyc == e.cyc, "R7 grant timing", cyc, e.cyc);
            end
        end
    end

    initial begin
        #(8 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int g0;
        for (int i = 0; i < NQ; i++) begin mw[i] = 0; mc[i] = 0; end
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(grant_valid == 1'b0, "R1 grant low after reset", int'(grant_valid), 0);

        // R1 R5: zero weights, all tied -> queue 0
        decide(8'hFF);
        decide(8'h0C); // R5 tie among 2,3 -> 2

        // R3 R4 R6: weighted mix
        for (int i = 0; i < NQ; i++) wr(i, i + 1);
        for (int k = 0; k < 40; k++) decide(NQ'((k * 37 + 11) & 8'hFF) | NQ'(1 << (k % NQ)));

        // R4 sign handling: large vs small weight, counters swing negative
        wr(0, 511); wr(1, 1); wr(2, 300);
        for (int k = 0; k < 12; k++) decide(8'h07);

        // R8: empty mask gives no grant, no counter change
        g0 = gcount;
        start(8'h00);
        idle(CW + 4);
        chk(gcount == g0, "R8 no grant on empty mask", gcount, g0);
        decide(8'h07);

        // R9: request and mask change while busy are ignored
        g0 = gcount;
        start(8'h30);
        idle(3);
        act_mask = 8'hC0; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        idle(CW + 4);
        chk(gcount == g0 + 1, "R9 single grant while busy", gcount, g0 + 1);

        // R10: weight write in the middle of a decision
        start(8'h0F);
        wr(3, 200);
        idle(CW + 2);
        decide(8'h0F);
        decide(8'h0F);

        // R2: write and accept on the same edge
        begin
            int w;
            exp_t e;
            @(negedge clk);
            act_mask = 8'h18; req = 1'b1;
            wt_we = 1'b1; wt_addr = QW'(4); wt_data = WW'(450);
            w = model(8'h18);
            e.id = w; e.cyc = cyc + CW + 2;
            sbq.push_back(e);
            mw[4] = 450;
            @(negedge clk);
            req = 1'b0; wt_we = 1'b0;
            idle(CW + 3);
        end
        for (int k = 0; k < 4; k++) decide(8'h18);

        idle(4);
        chk(sbq.size() == 0, "R7 all expected grants seen", sbq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule